// File: doc/BRIEF.md
# Grouped Interrupt Controller with Summary

This block gathers interrupt sources that arrive in four groups of equal width: local bus, low-pin-count/serial IRQ, PCI and on-chip devices, and non-maskable. Every raw input first passes a two-flop synchronizer. It is then turned into an active-high signal by its polarity bit. Its sensing bit selects one of two modes. In level mode the request follows the qualified input. In edge mode a selected edge sets a sticky request bit.

Each group has four registers that the host reads and writes through a simple word-addressed port: enable-mask, sensing, polarity and request. A summary word holds one bit per group. That bit is set when any unmasked source in the group has a pending request. The three ordinary groups drive one CPU interrupt line, and the non-maskable group drives a separate output. Software clears latched edge requests by writing the request register. A bit written as 0 clears its latch, and a bit written as 1 leaves it unchanged.

Top module: `grouped_irq_ctrl`

## Requirements
- R1: After reset every mask register reads 0xFFFF, every sensing and polarity register reads 0x0000, the summary reads 0, and both interrupt outputs are low. With all inputs low, every request register reads 0xFFFF, because active-low level sources are then asserted.
- R2: Word addresses are 4*g+0 for mask, 4*g+1 for sensing, 4*g+2 for polarity and 4*g+3 for request, where g is 0 for local bus, 1 for LPC, 2 for PCI/device and 3 for NMI. The summary is at address 16. Reads of addresses 17 and above return 0, and a write to the summary address changes nothing.
- R3: A polarity bit of 1 makes its source active high, and 0 makes it active low. In level mode (sensing bit 0), the request bit shows the qualified input two clock edges after the input changes.
- R4: A write to a request register does not clear a level-mode request bit while its input stays asserted.
- R5: In edge mode (sensing bit 1), a polarity of 1 latches on a rising input edge and a polarity of 0 latches on a falling edge. The latched bit stays set after the input returns, and the opposite edge sets nothing.
- R6: A write to a request register clears each latched edge request whose data bit is 0. Latched bits whose data bit is 1 are kept.
- R7: An edge detected in the same cycle as a clearing write to its request register still leaves the bit set.
- R8: Summary bit g equals the OR over group g of (request AND NOT mask). A mask bit of 1 disables its source. Summary bits 15..4 read 0.
- R9: cpuIrq is the OR of summary bits 0 to 2, and nmiIrq equals summary bit 3.
- R10: The mask, sensing and polarity registers read back the last value written to them.
- R11: Returning a source to level mode discards its latched edge request, and the request does not come back on a later return to edge mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| srcIn | input | 64 | Raw sources, group g at bits 16*g+15..16*g |
| regAddr | input | 5 | Word address for read and write |
| regWrEn | input | 1 | Write strobe, sampled at the clock edge |
| regWrData | input | 16 | Write data |
| regRdData | output | 16 | Combinational read data for regAddr |
| cpuIrq | output | 1 | Interrupt line for the three ordinary groups |
| nmiIrq | output | 1 | Non-maskable interrupt line |

## Verification
A corrupted synchronizer or previous-value flop appears in the request readback within three clock edges of an input change. It shows up either as a missed latch or as a spurious one. A lost or stuck edge latch stays visible in the request register until software writes a clear, so a single read after the stimulus finds it. A faulty mask or summary path shows at cpuIrq or nmiIrq in the same cycle as the request. The bench reads the summary word and compares it with both output pins.

// File: rtl/irqgrp_pkg.sv
package irqgrp_pkg;
  localparam int NUM_GRP      = 4;
  localparam int REGS_PER_GRP = 4;
  localparam int GRP_BITS     = $clog2(NUM_GRP);
  localparam int NMI_GRP      = NUM_GRP - 1;

  typedef enum logic [1:0] {
    FLD_MASK  = 2'd0,
    FLD_TRIG  = 2'd1,
    FLD_LEVEL = 2'd2,
    FLD_REQ   = 2'd3
  } fieldSel_t;

  typedef struct packed {
    logic [NUM_GRP-1:0]  wrMask;
    logic [NUM_GRP-1:0]  wrTrig;
    logic [NUM_GRP-1:0]  wrLevel;
    logic [NUM_GRP-1:0]  wrReq;
    logic                rdCfg;
    logic                rdSum;
    logic [GRP_BITS-1:0] rdGrp;
    logic [1:0]          rdFld;
  } ctlStrobe_t;
endpackage

// File: rtl/irqgrp_ctrl.sv
module irqgrp_ctrl
  import irqgrp_pkg::*;
#(
  parameter int ADDR_W = 5
) (
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWrEn,
  output ctlStrobe_t        strb
);
  localparam int SUM_ADDR = NUM_GRP * REGS_PER_GRP;

  logic                inGrp;
  logic                isSum;
  logic [GRP_BITS-1:0] grpSel;
  logic [1:0]          fldSel;

  assign inGrp  = (regAddr < ADDR_W'(SUM_ADDR));
  assign isSum  = (regAddr == ADDR_W'(SUM_ADDR));
  assign grpSel = regAddr[GRP_BITS+1:2];
  assign fldSel = regAddr[1:0];

  always_comb begin
    strb       = '0;
    strb.rdCfg = inGrp;
    strb.rdSum = isSum;
    strb.rdGrp = grpSel;
    strb.rdFld = fldSel;
    if (regWrEn && inGrp) begin
      case (fldSel)
        FLD_MASK:  strb.wrMask[grpSel]  = 1'b1;
        FLD_TRIG:  strb.wrTrig[grpSel]  = 1'b1;
        FLD_LEVEL: strb.wrLevel[grpSel] = 1'b1;
        default:   strb.wrReq[grpSel]   = 1'b1;
      endcase
    end
  end
endmodule

// File: rtl/irqgrp_dpath.sv
module irqgrp_dpath
  import irqgrp_pkg::*;
#(
  parameter int SRC_W = 16
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic [NUM_GRP*SRC_W-1:0] srcIn,
  input  logic [SRC_W-1:0]         wrData,
  input  ctlStrobe_t               strb,
  output logic [SRC_W-1:0]         rdData,
  output logic [NUM_GRP-1:0]       sumVec
);
  logic [REGS_PER_GRP-1:0][SRC_W-1:0] fldVal [NUM_GRP];

  for (genvar g = 0; g < NUM_GRP; g++) begin : gGrp
    logic [SRC_W-1:0] maskR, trigR, levelR, latchR;
    logic [SRC_W-1:0] syncA, syncB, prevQ;
    logic [SRC_W-1:0] qual, edgeHit, reqView, keepMask;

    // polarity: level bit 1 passes the input, 0 inverts it
    assign qual     = syncB ~^ levelR;
    assign edgeHit  = qual & ~prevQ;
    assign keepMask = strb.wrReq[g] ? wrData : '1;
    assign reqView  = (trigR & latchR) | (~trigR & qual);
    assign sumVec[g] = |(reqView & ~maskR);

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        maskR  <= '1;
        trigR  <= '0;
        levelR <= '0;
        latchR <= '0;
        syncA  <= '0;
        syncB  <= '0;
        prevQ  <= '0;
      end else begin
        syncA <= srcIn[g*SRC_W +: SRC_W];
        syncB <= syncA;
        prevQ <= qual;
        if (strb.wrMask[g])  maskR  <= wrData;
        if (strb.wrTrig[g])  trigR  <= wrData;
        if (strb.wrLevel[g]) levelR <= wrData;
        // a new edge wins over a clearing write; level mode holds no latch
        latchR <= trigR & ((latchR & keepMask) | edgeHit);
      end
    end

    assign fldVal[g][FLD_MASK]  = maskR;
    assign fldVal[g][FLD_TRIG]  = trigR;
    assign fldVal[g][FLD_LEVEL] = levelR;
    assign fldVal[g][FLD_REQ]   = reqView;
  end

  always_comb begin
    if (strb.rdSum)      rdData = SRC_W'(sumVec);
    else if (strb.rdCfg) rdData = fldVal[strb.rdGrp][strb.rdFld];
    else                 rdData = '0;
  end
endmodule

// File: rtl/grouped_irq_ctrl.sv
module grouped_irq_ctrl
  import irqgrp_pkg::*;
#(
  parameter int SRC_W  = 16,
  parameter int ADDR_W = 5
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic [NUM_GRP*SRC_W-1:0] srcIn,
  input  logic [ADDR_W-1:0]        regAddr,
  input  logic                     regWrEn,
  input  logic [SRC_W-1:0]         regWrData,
  output logic [SRC_W-1:0]         regRdData,
  output logic                     cpuIrq,
  output logic                     nmiIrq
);
  ctlStrobe_t         strb;
  logic [NUM_GRP-1:0] sumVec;

  irqgrp_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .regAddr (regAddr),
    .regWrEn (regWrEn),
    .strb    (strb)
  );

  irqgrp_dpath #(.SRC_W(SRC_W)) u_dpath (
    .clk    (clk),
    .rstN   (rstN),
    .srcIn  (srcIn),
    .wrData (regWrData),
    .strb   (strb),
    .rdData (regRdData),
    .sumVec (sumVec)
  );

  assign cpuIrq = |sumVec[NMI_GRP-1:0];
  assign nmiIrq = sumVec[NMI_GRP];
endmodule

// File: rtl/grouped_irq_ctrl_chk.sv
module grouped_irq_ctrl_chk
  import irqgrp_pkg::*;
#(
  parameter int SRC_W  = 16,
  parameter int ADDR_W = 5
) (
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] regAddr,
  input logic              regWrEn,
  input logic [SRC_W-1:0]  regWrData,
  input logic [SRC_W-1:0]  regRdData,
  input logic              cpuIrq,
  input logic              nmiIrq
);
  localparam logic [ADDR_W-1:0] SUM_A = ADDR_W'(NUM_GRP * REGS_PER_GRP);

  AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (regAddr > SUM_A) |-> (regRdData == '0)); // R2

  AST_CPU_FROM_SUMMARY: assert property (@(posedge clk) disable iff (!rstN)
    (regAddr == SUM_A) |-> (cpuIrq == |regRdData[NMI_GRP-1:0])); // R9

  AST_NMI_FROM_SUMMARY: assert property (@(posedge clk) disable iff (!rstN)
    (regAddr == SUM_A) |-> (nmiIrq == regRdData[NMI_GRP])); // R9

  AST_SUMMARY_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (regAddr == SUM_A) |-> (regRdData[SRC_W-1:NUM_GRP] == '0)); // R8

  AST_CFG_READBACK: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && (regAddr < SUM_A) && (regAddr[1:0] != 2'd3)) ##1
    (regAddr == $past(regAddr)) |-> (regRdData == $past(regWrData))); // R10
endmodule

bind grouped_irq_ctrl grouped_irq_ctrl_chk #(.SRC_W(SRC_W), .ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .regAddr   (regAddr),
  .regWrEn   (regWrEn),
  .regWrData (regWrData),
  .regRdData (regRdData),
  .cpuIrq    (cpuIrq),
  .nmiIrq    (nmiIrq)
);

// File: tb/grouped_irq_ctrl_bench.sv
`timescale 1ns/1ps
module grouped_irq_ctrl_bench;
  localparam int SRC_W = 16, ADDR_W = 5, NG = 4, SUM_A = 16;

  logic                 clk = 1'b0;
  logic                 rstN = 1'b0;
  logic [NG*SRC_W-1:0]  srcIn = '0;
  logic [ADDR_W-1:0]    regAddr = '0;
  logic                 regWrEn = 1'b0;
  logic [SRC_W-1:0]     regWrData = '0;
  logic [SRC_W-1:0]     regRdData;
  logic                 cpuIrq, nmiIrq;

  int nChk = 0, nFail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  grouped_irq_ctrl #(.SRC_W(SRC_W), .ADDR_W(ADDR_W)) u_grouped_irq_ctrl (
    .clk(clk), .rstN(rstN), .srcIn(srcIn), .regAddr(regAddr),
    .regWrEn(regWrEn), .regWrData(regWrData), .regRdData(regRdData),
    .cpuIrq(cpuIrq), .nmiIrq(nmiIrq)
  );

  task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
    nChk++;
    if (got !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", tag, got, exp);
    end
  endtask

  task automatic wr(int a, logic [15:0] d);
    @(negedge clk); regAddr = ADDR_W'(a); regWrData = d; regWrEn = 1'b1;
    @(negedge clk); regWrEn = 1'b0;
  endtask

  task automatic rdChk(string tag, int a, logic [15:0] exp);
    @(negedge clk); regAddr = ADDR_W'(a); #0.5;
    chk(tag, 32'(regRdData), 32'(exp));
  endtask

  task automatic setSrc(int g, int i, logic v);
    @(negedge clk); srcIn[g*SRC_W+i] = v;
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nChk++; nFail++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", nChk, nFail);
      $finish;
    end
  end

  initial begin
    logic [15:0] pats [3];
    pats[0] = 16'hA5A5; pats[1] = 16'h5A5A; pats[2] = 16'h0F0F;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    settle();

    // R1 reset values, R2 unmapped reads
    for (int g = 0; g < NG; g++) begin
      rdChk("R1 mask", 4*g,   16'hFFFF);
      rdChk("R1 trig", 4*g+1, 16'h0000);
      rdChk("R1 level", 4*g+2, 16'h0000);
      rdChk("R1 req", 4*g+3, 16'hFFFF);
    end
    rdChk("R1 summary", SUM_A, 16'h0000);
    chk("R1 cpuIrq", 32'(cpuIrq), 0);
    chk("R1 nmiIrq", 32'(nmiIrq), 0);
    for (int a = SUM_A + 1; a < 32; a++) rdChk("R2 unmapped", a, 16'h0000);

    // R3 polarity and level sensing sweep over every source
    for (int g = 0; g < NG; g++) wr(4*g+2, 16'hFFFF);
    settle();
    for (int g = 0; g < NG; g++) begin
      rdChk("R3 idle high", 4*g+3, 16'h0000);
      for (int i = 0; i < SRC_W; i++) begin
        setSrc(g, i, 1'b1);
        settle();
        rdChk("R3 level", 4*g+3, 16'(1 << i));
        rdChk("R8 masked", SUM_A, 16'h0000);
        setSrc(g, i, 1'b0);
      end
      wr(4*g+2, 16'hFFFE);
      settle();
      rdChk("R3 active low", 4*g+3, 16'h0001);
      wr(4*g+2, 16'hFFFF);
    end

    // R8/R9 summary and outputs per group
    for (int g = 0; g < NG; g++) begin
      wr(4*g, 16'hFFDF);
      setSrc(g, 5, 1'b1);
      settle();
      rdChk("R8 summary", SUM_A, 16'(1 << g));
      chk("R9 cpuIrq", 32'(cpuIrq), 32'(g < 3));
      chk("R9 nmiIrq", 32'(nmiIrq), 32'(g == 3));
      setSrc(g, 5, 1'b0);
      setSrc(g, 6, 1'b1);
      settle();
      rdChk("R8 other bit masked", SUM_A, 16'h0000);
      chk("R9 cpuIrq quiet", 32'(cpuIrq), 0);
      setSrc(g, 6, 1'b0);
      wr(4*g, 16'hFFFF);
    end
    wr(0, 16'hFFFD); wr(12, 16'hFFFD);
    setSrc(0, 1, 1'b1); setSrc(3, 1, 1'b1);
    settle();
    rdChk("R8 two groups", SUM_A, 16'h0009);
    chk("R9 cpuIrq both", 32'(cpuIrq), 1);
    chk("R9 nmiIrq both", 32'(nmiIrq), 1);
    setSrc(0, 1, 1'b0); setSrc(3, 1, 1'b0);
    wr(0, 16'hFFFF); wr(12, 16'hFFFF);
    settle();
    wr(SUM_A, 16'hFFFF);
    rdChk("R2 summary write ignored", SUM_A, 16'h0000);

    // R4 level request survives a clearing write
    setSrc(2, 7, 1'b1);
    settle();
    wr(11, 16'h0000);
    rdChk("R4 level not cleared", 11, 16'h0080);
    setSrc(2, 7, 1'b0);

    // R5 edge sensing on group 1
    wr(6, 16'h00FF);
    settle();
    wr(5, 16'hFFFF);
    settle();
    rdChk("R5 no spurious", 7, 16'h0000);
    setSrc(1, 3, 1'b1);
    setSrc(1, 3, 1'b0);
    settle();
    rdChk("R5 rising held", 7, 16'h0008);
    setSrc(1, 10, 1'b1);
    settle();
    rdChk("R5 rising ignored active low", 7, 16'h0008);
    setSrc(1, 10, 1'b0);
    settle();
    rdChk("R5 falling latched", 7, 16'h0408);
    wr(4, 16'hFBFF);
    rdChk("R8 edge summary", SUM_A, 16'h0002);
    chk("R9 cpuIrq edge", 32'(cpuIrq), 1);
    wr(4, 16'hFFFF);

    // R6 selective clear
    wr(7, 16'hFBFF);
    rdChk("R6 partial clear", 7, 16'h0008);
    wr(7, 16'h0000);
    rdChk("R6 full clear", 7, 16'h0000);

    // R7 edge coincident with clearing write
    setSrc(1, 4, 1'b1);
    @(negedge clk);
    wr(7, 16'h0000);
    settle();
    rdChk("R7 edge wins", 7, 16'h0010);
    setSrc(1, 4, 1'b0);
    settle();

    // R11 back to level mode drops latch
    wr(5, 16'hFFEF);
    settle();
    rdChk("R11 level view", 7, 16'h0000);
    wr(5, 16'hFFFF);
    settle();
    rdChk("R11 latch gone", 7, 16'h0000);

    // R10 configuration readback
    for (int g = 0; g < NG; g++)
      for (int f = 0; f < 3; f++)
        for (int p = 0; p < 3; p++) begin
          wr(4*g+f, pats[p]);
          rdChk("R10 readback", 4*g+f, pats[p]);
        end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChk, nFail);
    $finish;
  end
endmodule